// File: doc/BRIEF.md
# Semaphore Command Engine

The engine keeps a bank of counting semaphores and carries out 32-bit semaphore command words handed to it by one request sequencer. A command word can set a semaphore, step it up or down, wait until it reaches a given value, or take it with a P operation. Any enabled command may also be held back until the outstanding DMA traffic in one or both directions has drained. The engine works on one command at a time. A command is accepted through a valid/ready handshake, and its completion is signalled by a one-cycle `done` pulse. The pulse carries an error flag, the command's sync-position bit and the resulting semaphore value.

Other agents can overwrite any semaphore through a separate update port. While a wait or P command is pending, the engine tests its condition again on every cycle against the current contents of the bank. An external update therefore releases a blocked command without the sequencer doing anything. When a P command fires, the test for a non-zero value and the decrement happen in the same clock edge. If the command path and the update port write the same semaphore in that edge, the command path wins.

Command word layout, most significant bit first:

- bit 31: enable.
- bit 30: to-device fence. Bit 29: from-device fence.
- bits 26:24: opcode.
- bit 22: pre-sync flag.
- bits 20:16: semaphore index.
- bits 11:0: operand.
- bits 28:27, 23, 21 and 15:12: ignored.

Top module: `sema_cmd_engine`

## Requirements
- R1: After reset every semaphore reads 0, `cmd_ready` is 1 and `done` is 0.
- R2: A command with bit 31 clear completes on the second rising edge after acceptance, whatever the DMA busy inputs are. It changes no semaphore and reports `done_val` 0 with `done_err` 0.
- R3: Opcode 1 (init) writes the operand in bits 11:0 to the semaphore selected by bits 20:16 and reports that value.
- R4: Opcodes 2 and 3 add or subtract one, modulo 4096: 4095 plus one gives 0 and 0 minus one gives 4095. The new value is reported.
- R5: Opcode 4 (wait until equal) and opcode 5 (wait until unsigned greater-or-equal) hold completion until the condition holds. The condition is tested every cycle against the current value, including values written through the update port. These opcodes leave the semaphore unchanged and report its value.
- R6: Opcode 6 (P) holds while the semaphore is 0. Once the semaphore is non-zero, the command decrements it by one in the same edge as the test and reports the decremented value.
- R7: If the command path writes a semaphore in the same edge as an external update to the same index, the command's result is stored. An external update to a different index in that edge still takes effect.
- R8: An enabled command with bit 30 set does not complete while `tod_busy` is 1. With bit 29 set it does not complete while `frd_busy` is 1. A fence bit that is clear ignores its busy input. Once the blocking input drops, the command completes at the next edge.
- R9: Opcode 7 completes with `done_err` 1 and `done_val` 0 and changes no semaphore. All other opcodes report `done_err` 0.
- R10: `done_presync` repeats bit 22 of the completed command. Setting bits 28:27, 23, 21 or 15:12 changes no result.
- R11: `cmd_ready` falls in the cycle after acceptance and rises with the `done` pulse. `done` lasts exactly one cycle. An unblocked command completes on the second edge after acceptance.
- R12: Opcode 0 (NOP) leaves the semaphore unchanged and reports its current value. An update-port write with `ext_we` 1 stores `ext_val` at `ext_idx` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command word offered |
| cmd_word | input | 32 | Packed semaphore command |
| cmd_ready | output | 1 | Engine idle, command taken when valid |
| tod_busy | input | 1 | To-device DMA traffic outstanding |
| frd_busy | input | 1 | From-device DMA traffic outstanding |
| ext_we | input | 1 | External semaphore write strobe |
| ext_idx | input | IDX_W (5) | External write index |
| ext_val | input | SEM_W (12) | External write value |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Completed command used the reserved opcode |
| done_presync | output | 1 | Pre-sync bit of the completed command |
| done_val | output | SEM_W (12) | Semaphore value after the completed command |

## Verification
On every cycle, the assertions check the handshake and pulse shape of R11, that an active fence or a zero P target suppresses completion, that an error only comes from the reserved opcode, and that the bank stores the command's result when both write ports collide on one index. Arithmetic wrap, the release of waits by external updates, the ignoring of reserved bits and disabled commands can only be shown by the bench. It sweeps every index and every opcode and compares the reported values against numbers it computes itself.

// File: rtl/sema_pkg.sv
package sema_pkg;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_INIT = 3'd1,
    OP_INC  = 3'd2,
    OP_DEC  = 3'd3,
    OP_WEQ  = 3'd4,
    OP_WGE  = 3'd5,
    OP_TAKE = 3'd6,
    OP_RSV  = 3'd7
  } sem_op_e;

  localparam int FLD_EN     = 31;
  localparam int FLD_FTOD   = 30;
  localparam int FLD_FFRD   = 29;
  localparam int FLD_OP_LSB = 24;
  localparam int FLD_PRE    = 22;
  localparam int FLD_IX_LSB = 16;
  localparam int FLD_IX_W   = 5;
  localparam int FLD_VAL_W  = 12;

  typedef struct packed {
    logic                 en;
    logic                 fence_tod;
    logic                 fence_frd;
    logic                 presync;
    sem_op_e              op;
    logic [FLD_IX_W-1:0]  idx;
    logic [FLD_VAL_W-1:0] val;
  } sem_cmd_t;

endpackage

// File: rtl/sema_decode.sv
module sema_decode
  import sema_pkg::*;
(
  input  logic [31:0] word,
  output sem_cmd_t    cmd
);

  logic unused_rsv;
  assign unused_rsv = ^{word[28:27], word[23], word[21], word[15:12]};

  always_comb begin
    cmd.en        = word[FLD_EN];
    cmd.fence_tod = word[FLD_FTOD];
    cmd.fence_frd = word[FLD_FFRD];
    cmd.presync   = word[FLD_PRE];
    cmd.op        = sem_op_e'(word[FLD_OP_LSB +: 3]);
    cmd.idx       = word[FLD_IX_LSB +: FLD_IX_W];
    cmd.val       = word[FLD_VAL_W-1:0];
  end

endmodule

// File: rtl/sema_bank.sv
module sema_bank #(
  parameter int NUM_SEM = 32,
  parameter int SEM_W   = 12,
  localparam int IDX_W  = $clog2(NUM_SEM)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [SEM_W-1:0] rd_val,
  input  logic             cmd_we,
  input  logic [IDX_W-1:0] cmd_idx,
  input  logic [SEM_W-1:0] cmd_wdata,
  input  logic             ext_we,
  input  logic [IDX_W-1:0] ext_idx,
  input  logic [SEM_W-1:0] ext_wdata
);

  logic [SEM_W-1:0] mem [NUM_SEM];
  logic             ext_hit;

  assign ext_hit = ext_we && !(cmd_we && (cmd_idx == ext_idx));
  assign rd_val  = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_SEM; i++) mem[i] <= '0;
    end else begin
      if (ext_hit) mem[ext_idx] <= ext_wdata;
      if (cmd_we)  mem[cmd_idx] <= cmd_wdata;
    end
  end

  // R7
  collide_cmd_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && ext_we && cmd_idx == ext_idx) |=> (mem[$past(cmd_idx)] == $past(cmd_wdata)));

  // R12
  ext_store_chk: assert property (@(posedge clk) disable iff (rst)
    (ext_we && !cmd_we) |=> (mem[$past(ext_idx)] == $past(ext_wdata)));

endmodule

// File: rtl/sema_ctrl.sv
module sema_ctrl
  import sema_pkg::*;
#(
  parameter int SEM_W = 12,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  sem_cmd_t         cmd_in,
  output logic             cmd_ready,
  input  logic             tod_busy,
  input  logic             frd_busy,
  output logic [IDX_W-1:0] sem_idx,
  input  logic [SEM_W-1:0] sem_rd,
  output logic             sem_we,
  output logic [SEM_W-1:0] sem_wdata,
  output logic             done,
  output logic             done_err,
  output logic             done_presync,
  output logic [SEM_W-1:0] done_val
);

  logic             busy;
  sem_cmd_t         held;
  logic             fenced, cond_ok, op_we, op_err, fire;
  logic [SEM_W-1:0] operand, nxt, result;

  assign operand   = held.val[SEM_W-1:0];
  assign sem_idx   = held.idx[IDX_W-1:0];
  assign cmd_ready = !busy;

  always_comb begin
    fenced  = held.en && ((held.fence_tod && tod_busy) || (held.fence_frd && frd_busy));
    cond_ok = 1'b1;
    op_we   = 1'b0;
    op_err  = 1'b0;
    nxt     = sem_rd;
    result  = sem_rd;
    unique case (held.op)
      OP_INIT: begin op_we = 1'b1; nxt = operand; result = operand; end
      OP_INC:  begin op_we = 1'b1; nxt = sem_rd + SEM_W'(1); result = nxt; end
      OP_DEC:  begin op_we = 1'b1; nxt = sem_rd - SEM_W'(1); result = nxt; end
      OP_WEQ:  cond_ok = (sem_rd == operand);
      OP_WGE:  cond_ok = (sem_rd >= operand);
      OP_TAKE: begin
        cond_ok = (sem_rd != '0);
        op_we   = 1'b1;
        nxt     = sem_rd - SEM_W'(1);
        result  = nxt;
      end
      OP_RSV:  begin op_err = 1'b1; result = '0; end
      default: ;
    endcase
    if (!held.en) begin
      cond_ok = 1'b1;
      op_we   = 1'b0;
      op_err  = 1'b0;
      result  = '0;
    end
    fire      = busy && cond_ok && !fenced;
    sem_we    = fire && op_we;
    sem_wdata = nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy         <= 1'b0;
      held         <= '0;
      done         <= 1'b0;
      done_err     <= 1'b0;
      done_presync <= 1'b0;
      done_val     <= '0;
    end else begin
      done <= fire;
      if (fire) begin
        done_err     <= op_err;
        done_presync <= held.presync;
        done_val     <= result;
        busy         <= 1'b0;
      end else if (!busy && cmd_valid) begin
        busy <= 1'b1;
        held <= cmd_in;
      end
    end
  end

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);

  // R11
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  // R8
  fence_tod_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && held.en && held.fence_tod && tod_busy) |=> !done);

  // R8
  fence_frd_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && held.en && held.fence_frd && frd_busy) |=> !done);

  // R6
  take_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && held.en && held.op == OP_TAKE && sem_rd == '0) |=> !done);

  // R9
  err_source_chk: assert property (@(posedge clk) disable iff (rst)
    (done && done_err) |-> (held.en && held.op == OP_RSV));

endmodule

// File: rtl/sema_cmd_engine.sv
module sema_cmd_engine
  import sema_pkg::*;
#(
  parameter int NUM_SEM = 32,
  parameter int SEM_W   = 12,
  localparam int IDX_W  = $clog2(NUM_SEM)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [31:0]      cmd_word,
  output logic             cmd_ready,
  input  logic             tod_busy,
  input  logic             frd_busy,
  input  logic             ext_we,
  input  logic [IDX_W-1:0] ext_idx,
  input  logic [SEM_W-1:0] ext_val,
  output logic             done,
  output logic             done_err,
  output logic             done_presync,
  output logic [SEM_W-1:0] done_val
);

  sem_cmd_t         dec_cmd;
  logic [IDX_W-1:0] sem_idx;
  logic [SEM_W-1:0] sem_rd, sem_wdata;
  logic             sem_we;

  sema_decode u_decode (
    .word (cmd_word),
    .cmd  (dec_cmd)
  );

  sema_ctrl #(.SEM_W(SEM_W), .IDX_W(IDX_W)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .cmd_valid    (cmd_valid),
    .cmd_in       (dec_cmd),
    .cmd_ready    (cmd_ready),
    .tod_busy     (tod_busy),
    .frd_busy     (frd_busy),
    .sem_idx      (sem_idx),
    .sem_rd       (sem_rd),
    .sem_we       (sem_we),
    .sem_wdata    (sem_wdata),
    .done         (done),
    .done_err     (done_err),
    .done_presync (done_presync),
    .done_val     (done_val)
  );

  sema_bank #(.NUM_SEM(NUM_SEM), .SEM_W(SEM_W)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .rd_idx    (sem_idx),
    .rd_val    (sem_rd),
    .cmd_we    (sem_we),
    .cmd_idx   (sem_idx),
    .cmd_wdata (sem_wdata),
    .ext_we    (ext_we),
    .ext_idx   (ext_idx),
    .ext_wdata (ext_val)
  );

endmodule

// File: tb/test_sema_cmd_engine.sv
`timescale 1ns/1ps
module test_sema_cmd_engine;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [31:0] cmd_word = '0;
  logic        cmd_ready;
  logic        tod_busy = 1'b0;
  logic        frd_busy = 1'b0;
  logic        ext_we = 1'b0;
  logic [4:0]  ext_idx = '0;
  logic [11:0] ext_val = '0;
  logic        done, done_err, done_presync;
  logic [11:0] done_val;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  sema_cmd_engine i_sema_cmd_engine (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .cmd_ready(cmd_ready), .tod_busy(tod_busy), .frd_busy(frd_busy),
    .ext_we(ext_we), .ext_idx(ext_idx), .ext_val(ext_val), .done(done),
    .done_err(done_err), .done_presync(done_presync), .done_val(done_val)
  );

  localparam logic [31:0] RSV_MASK = 32'h18A0_F000;

  function automatic logic [31:0] mk(bit en, bit ft, bit ff, bit pre,
                                     int op, int idx, int val);
    logic [2:0]  o = op[2:0];
    logic [4:0]  x = idx[4:0];
    logic [11:0] v = val[11:0];
    return {en, ft, ff, 2'b00, o, 1'b0, pre, 1'b0, x, 4'b0000, v};
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send(logic [31:0] w);
    @(negedge clk);
    cmd_word  = w;
    cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // Called right after send: first negedge after acceptance already passed.
  task automatic wait_done(output int lat);
    lat = 1;
    while (!done && lat < 60) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic run(logic [31:0] w, output int lat, output int val, output int err);
    send(w);
    wait_done(lat);
    val = done_val;
    err = done_err;
  endtask

  task automatic peek(int idx, output int val);
    int lat, err;
    run(mk(1, 0, 0, 0, 0, idx, 0), lat, val, err);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int lat, val, err;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 ready", cmd_ready, 1);
    check("R1 done", done, 0);
    for (int i = 0; i < 32; i++) begin
      peek(i, val);
      check("R1 zero after reset", val, 0);
    end

    // R3 init every index, R12 readback and handshake
    for (int i = 0; i < 32; i++) begin
      send(mk(1, 0, 0, 0, 1, i, (i * 97 + 5) % 4096));
      check("R11 ready low while busy", cmd_ready, 0);
      check("R11 no early done", done, 0);
      wait_done(lat);
      check("R11 latency", lat, 2);
      check("R3 init value", done_val, (i * 97 + 5) % 4096);
      check("R9 no err", done_err, 0);
      check("R11 ready with done", cmd_ready, 1);
      @(negedge clk);
      check("R11 done one cycle", done, 0);
    end
    for (int i = 0; i < 32; i++) begin
      peek(i, val);
      check("R12 nop readback", val, (i * 97 + 5) % 4096);
    end

    // R4 inc/dec sweep including wrap
    for (int v = 0; v < 4096; v += 455) begin
      run(mk(1, 0, 0, 0, 1, 2, v), lat, val, err);
      run(mk(1, 0, 0, 0, 2, 2, 0), lat, val, err);
      check("R4 inc", val, (v + 1) % 4096);
      run(mk(1, 0, 0, 0, 3, 2, 0), lat, val, err);
      run(mk(1, 0, 0, 0, 3, 2, 0), lat, val, err);
      check("R4 dec", val, (v + 4095) % 4096);
    end
    run(mk(1, 0, 0, 0, 1, 2, 4095), lat, val, err);
    run(mk(1, 0, 0, 0, 2, 2, 0), lat, val, err);
    check("R4 inc wrap", val, 0);
    run(mk(1, 0, 0, 0, 3, 2, 0), lat, val, err);
    check("R4 dec wrap", val, 4095);

    // R2 disabled command ignores fences, no effect
    tod_busy = 1'b1; frd_busy = 1'b1;
    run(mk(0, 1, 1, 0, 1, 3, 77), lat, val, err);
    check("R2 latency", lat, 2);
    check("R2 val", val, 0);
    check("R2 err", err, 0);
    tod_busy = 1'b0; frd_busy = 1'b0;
    peek(3, val);
    check("R2 unchanged", val, (3 * 97 + 5) % 4096);

    // R9 reserved opcode
    run(mk(1, 0, 0, 0, 7, 3, 55), lat, val, err);
    check("R9 err", err, 1);
    check("R9 val", val, 0);
    peek(3, val);
    check("R9 unchanged", val, (3 * 97 + 5) % 4096);

    // R10 presync reporting and ignored reserved bits
    send(mk(1, 0, 0, 1, 0, 4, 0));
    wait_done(lat);
    check("R10 presync 1", done_presync, 1);
    send(mk(1, 0, 0, 0, 0, 4, 0));
    wait_done(lat);
    check("R10 presync 0", done_presync, 0);
    run(mk(1, 0, 0, 0, 1, 4, 1234) | RSV_MASK, lat, val, err);
    check("R10 rsv bits init", val, 1234);
    check("R10 rsv bits err", err, 0);
    peek(4, val);
    check("R10 rsv bits stored", val, 1234);

    // R8 fences
    tod_busy = 1'b1;
    send(mk(1, 1, 0, 0, 0, 4, 0));
    repeat (5) begin
      check("R8 tod fence holds", done, 0);
      @(negedge clk);
    end
    tod_busy = 1'b0;
    @(negedge clk);
    check("R8 tod release", done, 1);
    frd_busy = 1'b1;
    run(mk(1, 1, 0, 0, 0, 4, 0), lat, val, err);
    check("R8 unrelated busy ignored", lat, 2);
    send(mk(1, 0, 1, 0, 2, 4, 0));
    repeat (4) begin
      check("R8 frd fence holds", done, 0);
      @(negedge clk);
    end
    frd_busy = 1'b0;
    @(negedge clk);
    check("R8 frd release", done, 1);
    check("R8 frd result", done_val, 1235);

    // R5 wait until equal, released by external write
    run(mk(1, 0, 0, 0, 1, 5, 10), lat, val, err);
    send(mk(1, 0, 0, 0, 4, 5, 12));
    repeat (5) begin
      check("R5 weq holds", done, 0);
      @(negedge clk);
    end
    ext_we = 1'b1; ext_idx = 5; ext_val = 12;
    @(negedge clk);
    ext_we = 1'b0;
    check("R12 ext write then eval", done, 0);
    @(negedge clk);
    check("R5 weq release", done, 1);
    check("R5 weq val", done_val, 12);
    run(mk(1, 0, 0, 0, 5, 5, 11), lat, val, err);
    check("R5 wge immediate", lat, 2);
    check("R5 wge val", val, 12);
    send(mk(1, 0, 0, 0, 5, 5, 13));
    repeat (3) begin
      check("R5 wge holds", done, 0);
      @(negedge clk);
    end
    ext_we = 1'b1; ext_idx = 5; ext_val = 4095;
    @(negedge clk);
    ext_we = 1'b0;
    @(negedge clk);
    check("R5 wge release", done, 1);
    check("R5 wge val", done_val, 4095);
    peek(5, val);
    check("R5 wait no change", val, 4095);

    // R6 P operation
    run(mk(1, 0, 0, 0, 1, 7, 0), lat, val, err);
    send(mk(1, 0, 0, 0, 6, 7, 0));
    repeat (4) begin
      check("R6 P holds at zero", done, 0);
      @(negedge clk);
    end
    ext_we = 1'b1; ext_idx = 7; ext_val = 3;
    @(negedge clk);
    ext_we = 1'b0;
    @(negedge clk);
    check("R6 P release", done, 1);
    check("R6 P val", done_val, 2);
    run(mk(1, 0, 0, 0, 1, 7, 1), lat, val, err);
    run(mk(1, 0, 0, 0, 6, 7, 0), lat, val, err);
    check("R6 P on one lat", lat, 2);
    check("R6 P on one val", val, 0);
    peek(7, val);
    check("R6 P stored", val, 0);

    // R7 collisions
    run(mk(1, 0, 0, 0, 1, 8, 5), lat, val, err);
    send(mk(1, 0, 0, 0, 2, 8, 0));
    ext_we = 1'b1; ext_idx = 8; ext_val = 100;
    @(negedge clk);
    ext_we = 1'b0;
    check("R7 done", done, 1);
    peek(8, val);
    check("R7 cmd wins", val, 6);
    send(mk(1, 0, 0, 0, 2, 8, 0));
    ext_we = 1'b1; ext_idx = 9; ext_val = 321;
    @(negedge clk);
    ext_we = 1'b0;
    peek(8, val);
    check("R7 cmd side", val, 7);
    peek(9, val);
    check("R7 other index", val, 321);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule